// File: doc/BRIEF.md
# Codec Control Register File

This block is the control register store of an audio codec. A serial front end, which is not part of this block, has already turned link traffic into a word address, a write strobe with sixteen bits of write data, and a read address. This block stores those words and returns read data. It holds the following settings:

- output and input volume with mutes
- record source and record gain
- a general-purpose loopback bit
- power-down requests
- the variable-rate enable
- two sample-rate words
- serial slot configuration
- miscellaneous routing bits
- fixed identification words

Reads are combinational from the address. A write is stored on the next rising clock edge. The block also applies several rules of its own:

- Only the defined bits of a word can be written. All other bits read zero.
- Odd addresses map to the even address just below them.
- Each sample-rate word has a second address that works only while variable rate is on.
- Sample-rate writes are clamped to the supported range.
- Clearing the variable-rate enable returns both rates to 48 kHz.
- A write of any value to address 0x00 restores every register to its default, except the serial configuration word.

Top module: `codec_regfile`

## Requirements
- R1: After hardware reset, reads return the following values:
  - 0x04 = 0x8000
  - 0x0E = 0x8008
  - 0x10, 0x12 and 0x18 = 0x8808
  - 0x1C = 0x8000
  - 0x1A = 0x0000
  - 0x20 = 0x0000
  - 0x2A = 0x0000
  - 0x26 = 0x000F
  - 0x74 = 0x7000
  - 0x76 = 0x0404
  - 0x7A and 0x78 = 0xBB80
  - 0x00 = 0x0010
  - 0x28 = 0x0001
  - 0x7C = 0x4144
  - 0x7E = 0x5362
- R2: Only the defined bits of each register are stored. All other bits read zero. A write of 0xFFFF reads back as follows:
  - 0x04 = 0xBF3F
  - 0x0E = 0x805F
  - 0x10 = 0x9F1F
  - 0x1A = 0x0707
  - 0x1C = 0x8F0F
  - 0x20 = 0x0080
  - 0x26 = 0x7F0F
  - 0x2A = 0x0001
  - 0x74 = 0xF000
  - 0x76 = 0xDDE5
- R3: Address bit 0 is ignored on both reads and writes. An odd address reaches the register at the even address below it.
- R4: A write of any value to 0x00 sets every writable register to its R1 default on the next edge, except 0x74, which keeps its value.
- R5: The following words are read-only, and writes to them have no effect:
  - 0x00, 0x28, 0x7C and 0x7E
  - bits 3:0 of 0x26, which always read 1111
- R6: A write to a sample-rate word is stored clamped to the range 0x1B80 to 0xBB80. Reads return the stored value.
- R7: Address 0x2C mirrors the rate at 0x7A, and 0x32 mirrors the rate at 0x78, only while bit 0 of 0x2A (the variable-rate enable) is 1. While that bit is 0, the mirror addresses read 0x0000 and writes to them are ignored.
- R8: A write to 0x2A with bit 0 = 0 sets both rate words to 0xBB80 on the next edge.
- R9: A write to an address not listed in R1 is ignored, and a read of such an address returns 0x0000.
- R10: Read data follows the address in the same cycle. A write becomes visible after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 7 | Word address for both the read and the write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |

## Verification
The hardest state to reach is the interaction between the mirror addresses and the variable-rate enable. A mirror write is ignored while the enable is clear. Once the enable is set, the same mirror write lands in the primary word. Clearing the enable again must then wipe both rates, not just the one that was written. The stimulus first writes a mirror address with the enable clear and reads the primary word to confirm nothing changed. It then sets the enable, writes through an odd mirror alias, and clears the enable again. Soft-reset preservation is reached in a similar way: the serial configuration word is first loaded with a non-default value next to other modified registers, and only then is address 0x00 written.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int DW    = 16;
  localparam int AW    = 7;
  localparam int N_CTL = 12;
  localparam int N_RATE = 2;

  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] word_t;

  // Plain control entries, index 0 is the lowest address
  localparam logic [N_CTL-1:0][AW-1:0] CTL_ADDR = {
    7'h76, 7'h74, 7'h2A, 7'h26, 7'h20, 7'h1C,
    7'h1A, 7'h18, 7'h12, 7'h10, 7'h0E, 7'h04};
  localparam logic [N_CTL-1:0][DW-1:0] CTL_DFLT = {
    16'h0404, 16'h7000, 16'h0000, 16'h0000, 16'h0000, 16'h8000,
    16'h0000, 16'h8808, 16'h8808, 16'h8808, 16'h8008, 16'h8000};
  localparam logic [N_CTL-1:0][DW-1:0] CTL_MASK = {
    16'hDDE5, 16'hF000, 16'h0001, 16'h7F00, 16'h0080, 16'h8F0F,
    16'h0707, 16'h9F1F, 16'h9F1F, 16'h9F1F, 16'h805F, 16'hBF3F};
  // Entries that survive the register-write reset
  localparam logic [N_CTL-1:0] CTL_KEEP = 12'b0100_0000_0000;

  localparam int IDX_PWR = 8;
  localparam int IDX_EXT = 9;

  // Rate words: index 0 = playback rate, index 1 = capture rate
  localparam logic [N_RATE-1:0][AW-1:0] RATE_ADDR     = {7'h78, 7'h7A};
  localparam logic [N_RATE-1:0][AW-1:0] RATE_ADDR_ALT = {7'h32, 7'h2C};

  localparam word_t RATE_MIN  = 16'h1B80;
  localparam word_t RATE_MAX  = 16'hBB80;
  localparam word_t RATE_DFLT = 16'hBB80;

  localparam addr_t A_SOFTRST = 7'h00;
  localparam addr_t A_EXTID   = 7'h28;
  localparam addr_t A_VEND1   = 7'h7C;
  localparam addr_t A_VEND2   = 7'h7E;

  localparam word_t V_CAPS    = 16'h0010;
  localparam word_t V_EXTID   = 16'h0001;
  localparam word_t V_VEND1   = 16'h4144;
  localparam word_t V_VEND2   = 16'h5362;
  localparam word_t V_READY   = 16'h000F;

  function automatic word_t clamp_rate(input word_t v);
    if (v < RATE_MIN)      return RATE_MIN;
    else if (v > RATE_MAX) return RATE_MAX;
    else                   return v;
  endfunction
endpackage

// File: rtl/crf_decode.sv
module crf_decode
  import codec_regs_pkg::*;
(
  input  logic [AW-1:0]     addr,
  input  logic              vra,
  output logic [AW-1:0]     word_addr,
  output logic [N_CTL-1:0]  ctl_sel,
  output logic [N_RATE-1:0] rate_sel,
  output logic              fixed_hit,
  output logic [DW-1:0]     fixed_val
);
  assign word_addr = {addr[AW-1:1], 1'b0};

  for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
    assign ctl_sel[i] = (word_addr == CTL_ADDR[i]);
  end

  for (genvar r = 0; r < N_RATE; r++) begin : g_rate
    assign rate_sel[r] = (word_addr == RATE_ADDR[r]) ||
                         (vra && (word_addr == RATE_ADDR_ALT[r]));
  end

  always_comb begin
    fixed_hit = 1'b1;
    fixed_val = '0;
    case (word_addr)
      A_SOFTRST: fixed_val = V_CAPS;
      A_EXTID:   fixed_val = V_EXTID;
      A_VEND1:   fixed_val = V_VEND1;
      A_VEND2:   fixed_val = V_VEND2;
      default:   fixed_hit = 1'b0;
    endcase
  end

  // R3 R9: each address reaches at most one storage location
  always_comb begin
    if (!$isunknown(addr)) begin
      single_target_chk: assert ($onehot0({ctl_sel, rate_sel, fixed_hit}));
    end
  end
endmodule

// File: rtl/crf_ctl_bank.sv
module crf_ctl_bank
  import codec_regs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [N_CTL-1:0]          sel,
  input  logic [DW-1:0]             wdata,
  input  logic                      soft_rst,
  output logic [N_CTL-1:0][DW-1:0]  q,
  output logic [DW-1:0]             rd_word
);
  for (genvar i = 0; i < N_CTL; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q[i] <= CTL_DFLT[i];
      else if (soft_rst && !CTL_KEEP[i]) q[i] <= CTL_DFLT[i];
      else if (wr_en && sel[i])          q[i] <= wdata & CTL_MASK[i];
    end

    // R9: without a write strobe nothing changes
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q[i]));

    if (CTL_KEEP[i]) begin : g_keep
      // R4
      keep_on_softrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> q[i] == $past(q[i]));
    end else begin : g_clr
      // R4
      dflt_on_softrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> q[i] == CTL_DFLT[i]);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N_CTL; i++) begin
      if (sel[i]) rd_word = rd_word | q[i];
    end
  end
endmodule

// File: rtl/crf_rate_pair.sv
module crf_rate_pair
  import codec_regs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [N_RATE-1:0]         sel,
  input  logic [DW-1:0]             wdata,
  input  logic                      clr,
  output logic [N_RATE-1:0][DW-1:0] rate,
  output logic [DW-1:0]             rd_word
);
  for (genvar r = 0; r < N_RATE; r++) begin : g_rate
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rate[r] <= RATE_DFLT;
      else if (clr)            rate[r] <= RATE_DFLT;
      else if (wr_en && sel[r]) rate[r] <= clamp_rate(wdata);
    end

    // R6
    rate_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate[r] >= RATE_MIN) && (rate[r] <= RATE_MAX));

    // R8
    rate_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> rate[r] == RATE_DFLT);
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < N_RATE; r++) begin
      if (sel[r]) rd_word = rd_word | rate[r];
    end
  end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [6:0]    addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [AW-1:0]             word_addr;
  logic [N_CTL-1:0]          ctl_sel;
  logic [N_RATE-1:0]         rate_sel;
  logic                      fixed_hit;
  logic [DW-1:0]             fixed_val;
  logic [N_CTL-1:0][DW-1:0]  ctl_q;
  logic [DW-1:0]             ctl_rd;
  logic [N_RATE-1:0][DW-1:0] rate_q;
  logic [DW-1:0]             rate_rd;
  logic                      vra;

  // Named internal events
  logic soft_rst_evt;
  logic vra_clr_evt;
  logic rate_clr_evt;

  assign vra          = ctl_q[IDX_EXT][0];
  assign soft_rst_evt = wr_en && (word_addr == A_SOFTRST);
  assign vra_clr_evt  = wr_en && ctl_sel[IDX_EXT] && !wdata[0];
  assign rate_clr_evt = soft_rst_evt || vra_clr_evt;

  crf_decode u_dec (
    .addr      (addr),
    .vra       (vra),
    .word_addr (word_addr),
    .ctl_sel   (ctl_sel),
    .rate_sel  (rate_sel),
    .fixed_hit (fixed_hit),
    .fixed_val (fixed_val)
  );

  crf_ctl_bank u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel      (ctl_sel),
    .wdata    (wdata),
    .soft_rst (soft_rst_evt),
    .q        (ctl_q),
    .rd_word  (ctl_rd)
  );

  crf_rate_pair u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sel     (rate_sel),
    .wdata   (wdata),
    .clr     (rate_clr_evt),
    .rate    (rate_q),
    .rd_word (rate_rd)
  );

  always_comb begin
    rdata = ctl_rd | rate_rd;
    if (fixed_hit)        rdata = rdata | fixed_val;
    if (ctl_sel[IDX_PWR]) rdata = rdata | V_READY;
  end

  // R7: variable rate disabled leaves the mirror addresses unmapped
  mirror_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vra && (word_addr == RATE_ADDR_ALT[0])) |-> (rdata == '0));

  // R4: the variable-rate enable is cleared by the register-write reset
  softrst_vra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> !vra);
endmodule

// File: tb/codec_regfile_bench.sv
module codec_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  codec_regfile u_codec_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic t_defaults();
    rd_chk(7'h04, 16'h8000, "R1"); rd_chk(7'h0E, 16'h8008, "R1");
    rd_chk(7'h10, 16'h8808, "R1"); rd_chk(7'h12, 16'h8808, "R1");
    rd_chk(7'h18, 16'h8808, "R1"); rd_chk(7'h1A, 16'h0000, "R1");
    rd_chk(7'h1C, 16'h8000, "R1"); rd_chk(7'h20, 16'h0000, "R1");
    rd_chk(7'h26, 16'h000F, "R1"); rd_chk(7'h2A, 16'h0000, "R1");
    rd_chk(7'h74, 16'h7000, "R1"); rd_chk(7'h76, 16'h0404, "R1");
    rd_chk(7'h7A, 16'hBB80, "R1"); rd_chk(7'h78, 16'hBB80, "R1");
    rd_chk(7'h00, 16'h0010, "R1"); rd_chk(7'h28, 16'h0001, "R1");
    rd_chk(7'h7C, 16'h4144, "R1"); rd_chk(7'h7E, 16'h5362, "R1");
  endtask

  task automatic t_masks();
    wr(7'h04, 16'hFFFF); rd_chk(7'h04, 16'hBF3F, "R2");
    wr(7'h0E, 16'hFFFF); rd_chk(7'h0E, 16'h805F, "R2");
    wr(7'h10, 16'hFFFF); rd_chk(7'h10, 16'h9F1F, "R2");
    wr(7'h1A, 16'hFFFF); rd_chk(7'h1A, 16'h0707, "R2");
    wr(7'h1C, 16'hFFFF); rd_chk(7'h1C, 16'h8F0F, "R2");
    wr(7'h20, 16'hFFFF); rd_chk(7'h20, 16'h0080, "R2");
    wr(7'h26, 16'hFFFF); rd_chk(7'h26, 16'h7F0F, "R2");
    wr(7'h74, 16'hFFFF); rd_chk(7'h74, 16'hF000, "R2");
    wr(7'h76, 16'hFFFF); rd_chk(7'h76, 16'hDDE5, "R2");
    wr(7'h2A, 16'hFFFF); rd_chk(7'h2A, 16'h0001, "R2");
  endtask

  task automatic t_odd_alias();
    wr(7'h05, 16'h0102); rd_chk(7'h04, 16'h0102, "R3");
    rd_chk(7'h05, 16'h0102, "R3");
    wr(7'h13, 16'h0305); rd_chk(7'h12, 16'h0305, "R3");
    rd_chk(7'h7D, 16'h4144, "R3");
  endtask

  task automatic t_timing();
    // R10: data is not visible before the edge that stores it
    @(negedge clk);
    addr = 7'h18; wdata = 16'h0A0B; wr_en = 1'b1;
    #1; n_chk++;
    if (rdata !== 16'h8808) begin
      n_fail++; $display("FAIL R10 before edge actual=%h expected=%h", rdata, 16'h8808);
    end
    @(negedge clk); wr_en = 1'b0; #1; n_chk++;
    if (rdata !== 16'h0A0B) begin
      n_fail++; $display("FAIL R10 after edge actual=%h expected=%h", rdata, 16'h0A0B);
    end
  endtask

  task automatic t_readonly();
    wr(7'h28, 16'hFFFF); rd_chk(7'h28, 16'h0001, "R5");
    wr(7'h7C, 16'h0000); rd_chk(7'h7C, 16'h4144, "R5");
    wr(7'h7E, 16'h0000); rd_chk(7'h7E, 16'h5362, "R5");
    wr(7'h26, 16'h0000); rd_chk(7'h26, 16'h000F, "R5");
  endtask

  task automatic t_unlisted();
    wr(7'h40, 16'hFFFF); rd_chk(7'h40, 16'h0000, "R9");
    rd_chk(7'h22, 16'h0000, "R9");
    rd_chk(7'h04, 16'h0102, "R9");
  endtask

  task automatic t_clamp();
    wr(7'h7A, 16'h0000); rd_chk(7'h7A, 16'h1B80, "R6");
    wr(7'h7A, 16'h1B7F); rd_chk(7'h7A, 16'h1B80, "R6");
    wr(7'h7A, 16'h1B80); rd_chk(7'h7A, 16'h1B80, "R6");
    wr(7'h78, 16'hBB81); rd_chk(7'h78, 16'hBB80, "R6");
    wr(7'h78, 16'hFFFF); rd_chk(7'h78, 16'hBB80, "R6");
    wr(7'h78, 16'h5622); rd_chk(7'h78, 16'h5622, "R6");
  endtask

  task automatic t_mirror();
    wr(7'h2A, 16'h0000);
    rd_chk(7'h7A, 16'hBB80, "R8"); rd_chk(7'h78, 16'hBB80, "R8");
    wr(7'h2C, 16'h3000);
    rd_chk(7'h7A, 16'hBB80, "R7"); rd_chk(7'h2C, 16'h0000, "R7");
    wr(7'h2A, 16'h0001);
    wr(7'h2C, 16'h3000); rd_chk(7'h7A, 16'h3000, "R7");
    rd_chk(7'h2D, 16'h3000, "R7");
    wr(7'h33, 16'h4000); rd_chk(7'h78, 16'h4000, "R7");
    rd_chk(7'h32, 16'h4000, "R7");
    wr(7'h2A, 16'h0000);
    rd_chk(7'h7A, 16'hBB80, "R8"); rd_chk(7'h78, 16'hBB80, "R8");
    rd_chk(7'h32, 16'h0000, "R7");
  endtask

  task automatic t_softrst();
    wr(7'h74, 16'h1000);
    wr(7'h04, 16'h1234);
    wr(7'h2A, 16'h0001);
    wr(7'h7A, 16'h5622);
    wr(7'h01, 16'hABCD);
    rd_chk(7'h04, 16'h8000, "R4"); rd_chk(7'h74, 16'h1000, "R4");
    rd_chk(7'h7A, 16'hBB80, "R4"); rd_chk(7'h2A, 16'h0000, "R4");
    rd_chk(7'h76, 16'h0404, "R4"); rd_chk(7'h26, 16'h000F, "R4");
    rd_chk(7'h00, 16'h0010, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_defaults();
    t_masks();
    t_odd_alias();
    t_timing();
    t_readonly();
    t_unlisted();
    t_clamp();
    t_mirror();
    t_softrst();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule